// File: doc/BRIEF.md
# Periodic Waveform Code Sequencer

The block turns a handful of configuration controls into a stream of 10-bit codes for a digital-to-analog converter. While the run control is high, it steps the code between a programmed floor and a programmed ceiling. It can form one of four shapes: a triangle, a sawtooth that climbs and then snaps down, a sawtooth that descends and then snaps up, or a square wave. Two controls set the pace. The step selector gives the size of each move in LSBs. The pace selector gives the number of clock cycles between moves, and for the square wave it gives how long each level is held.

A central state machine owns the code register and works in these states:

- **IDLE**: generation is stopped.
- **CLIMB**: the code is rising.
- **DESCEND**: the code is falling.
- **SNAP_LO**: the next move jumps to the floor.
- **SNAP_HI**: the next move jumps to the ceiling.
- **SQ_LOW**: the square wave is at its low level.
- **SQ_HIGH**: the square wave is at its high level.
- **FLAT**: the ceiling is not above the floor.

The transitions are:

- IDLE goes to CLIMB, DESCEND, SQ_LOW or FLAT when the run control is seen high. This is the start transition.
- CLIMB goes to DESCEND (triangle) or to SNAP_LO (rising sawtooth) when a move reaches the ceiling.
- DESCEND goes to CLIMB (triangle) or to SNAP_HI (falling sawtooth) when a move reaches the floor.
- SNAP_LO goes to CLIMB, and SNAP_HI goes to DESCEND, on their next move.
- SQ_LOW and SQ_HIGH swap on each move.
- Any running state goes to FLAT when a move finds the bounds inverted or equal.
- FLAT goes to the shape's entry state on a move once the bounds are valid again.
- Every state goes to IDLE as soon as the run control is low.

A separate interval timer produces the move ticks. A combinational step unit computes clamped up and down candidates.

Top module: `wavegen_seq`

## Requirements
- R1: While `run_en` is 0, the state machine is IDLE. `code_out` holds its last value and `update_stb` stays 0. Clearing `run_en` mid-wave freezes the code on the next edge.
- R2: On the first edge with `run_en` at 1, `code_out` loads `code_lo` for shapes 0, 1 and 3. For shape 2 it loads `code_hi`.
- R3: Shape 0 (triangle) climbs from the floor to the ceiling and then descends back, repeating.
- R4: Shape 1 (rising sawtooth) climbs to the ceiling. The next move after reaching it sets the code straight to the floor, and the climb restarts.
- R5: Shape 2 (falling sawtooth) descends to the floor. The next move after reaching it sets the code straight to the ceiling.
- R6: Shape 3 (square) alternates `code_lo` and `code_hi` on each move, starting low.
- R7: Each ramp move changes the code by `step_sel + 1` LSB, where `step_sel` values 0 to 3 give 1 to 4.
- R8: A move that would pass a bound lands exactly on it. A move that lands on it (exactly or clamped) reverses or snaps the phase in the same move. The code never leaves [floor, ceiling] and never wraps.
- R9: Moves are spaced by an interval set by `pace_sel` = s. The interval is s+1 cycles for s below 8, and 2^(s-4) cycles for s from 8 to 15 (16 up to 2048). The first move comes one interval after the start edge.
- R10: If `code_hi` <= `code_lo`, the code holds `code_lo` and no further moves occur.
- R11: `update_stb` is 1 for exactly the cycles in which `code_out` differs from its value in the previous cycle.
- R12: After reset, `code_out` is 0 and `update_stb` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Generation enable |
| shape_sel | input | 2 | 0 triangle, 1 rising sawtooth, 2 falling sawtooth, 3 square |
| step_sel | input | 2 | Ramp step minus one, in LSBs |
| pace_sel | input | 4 | Move interval selector |
| code_hi | input | 10 | Ceiling code |
| code_lo | input | 10 | Floor code |
| code_out | output | 10 | Current output code |
| update_stb | output | 1 | One-cycle pulse when code_out changes |

## Verification
The bench targets moves that land exactly on a bound and moves that would overshoot one.

- A design that clamped late would show a repeated or out-of-range code.
- A design that reversed one move late would emit the bound twice.
- A ceiling of 1023 with a step of 4 exposes an adder that wraps instead of clamping.

Further directed tests cover the remaining corner cases:

- Both ends of the pace table, where a wrong shift produces a wrong spacing between strobes.
- Inverted and equal bounds, where a faulty design would ramp anyway.
- Stopping mid-wave, where a design that finished its pending move would show a late code change and strobe.

// File: rtl/wg_pkg.sv
package wg_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CLIMB,
        S_DESCEND,
        S_SNAP_LO,
        S_SNAP_HI,
        S_SQ_LOW,
        S_SQ_HIGH,
        S_FLAT
    } wg_state_e;

    typedef enum logic [1:0] {
        SH_TRIANGLE = 2'd0,
        SH_SAW_UP   = 2'd1,
        SH_SAW_DOWN = 2'd2,
        SH_SQUARE   = 2'd3
    } wg_shape_e;

endpackage

// File: rtl/wg_pace_timer.sv
module wg_pace_timer #(
    parameter int SEL_W      = 4,
    parameter int CNT_W      = 12,
    parameter int LIN_STEPS  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic [SEL_W-1:0] pace_sel,
    output logic             tick
);
    localparam int EXP_BIAS = LIN_STEPS / 2;

    logic [CNT_W-1:0] interval;
    logic [CNT_W-1:0] cnt_q;

    // linear section for small selectors, power-of-two section above it
    always_comb begin
        if (int'(pace_sel) < LIN_STEPS)
            interval = CNT_W'(pace_sel) + CNT_W'(1);
        else
            interval = CNT_W'(1) << (int'(pace_sel) - EXP_BIAS);
    end

    assign tick = running && (cnt_q == interval - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!running || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CNT_W'(1);
    end

    // R9: the counter never runs past the selected interval
    a_r9_count_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running) && $stable(pace_sel)) |-> (cnt_q < interval));

endmodule

// File: rtl/wg_step_unit.sv
module wg_step_unit #(
    parameter int CODE_W = 10,
    parameter int STEP_W = 2
) (
    input  logic [CODE_W-1:0] code_now,
    input  logic [STEP_W-1:0] step_sel,
    input  logic [CODE_W-1:0] ceil_code,
    input  logic [CODE_W-1:0] floor_code,
    output logic [CODE_W-1:0] up_code,
    output logic              up_hit,
    output logic [CODE_W-1:0] dn_code,
    output logic              dn_hit,
    output logic              bounds_ok
);
    localparam int EXT_W = CODE_W + 1;

    logic [CODE_W-1:0] step;
    logic [EXT_W-1:0]  up_sum;
    logic [EXT_W-1:0]  dn_lim;

    assign step      = CODE_W'(step_sel) + CODE_W'(1);
    assign up_sum    = {1'b0, code_now} + {1'b0, step};
    assign dn_lim    = {1'b0, floor_code} + {1'b0, step};
    assign up_hit    = up_sum >= {1'b0, ceil_code};
    assign dn_hit    = {1'b0, code_now} <= dn_lim;
    assign up_code   = up_hit ? ceil_code : up_sum[CODE_W-1:0];
    assign dn_code   = dn_hit ? floor_code : (code_now - step);
    assign bounds_ok = ceil_code > floor_code;

endmodule

// File: rtl/wg_seq_fsm.sv
module wg_seq_fsm
    import wg_pkg::*;
#(
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic [1:0]        shape_sel,
    input  logic              tick,
    input  logic [CODE_W-1:0] ceil_code,
    input  logic [CODE_W-1:0] floor_code,
    input  logic [CODE_W-1:0] up_code,
    input  logic              up_hit,
    input  logic [CODE_W-1:0] dn_code,
    input  logic              dn_hit,
    input  logic              bounds_ok,
    output logic              running,
    output logic [CODE_W-1:0] code_q,
    output logic              stb_q
);
    wg_state_e         state_q, state_d;
    wg_shape_e         shape;
    logic [CODE_W-1:0] code_d;
    logic [CODE_W-1:0] entry_code;
    wg_state_e         entry_state;

    assign shape   = wg_shape_e'(shape_sel);
    assign running = (state_q != S_IDLE);

    always_comb begin
        unique case (shape)
            SH_TRIANGLE, SH_SAW_UP: begin
                entry_state = S_CLIMB;
                entry_code  = floor_code;
            end
            SH_SAW_DOWN: begin
                entry_state = S_DESCEND;
                entry_code  = ceil_code;
            end
            SH_SQUARE: begin
                entry_state = S_SQ_LOW;
                entry_code  = floor_code;
            end
        endcase
    end

    always_comb begin
        state_d = state_q;
        code_d  = code_q;
        if (!run_en) begin
            state_d = S_IDLE;
        end else if (state_q == S_IDLE) begin
            if (bounds_ok) begin
                state_d = entry_state;
                code_d  = entry_code;
            end else begin
                state_d = S_FLAT;
                code_d  = floor_code;
            end
        end else if (tick) begin
            if (!bounds_ok) begin
                if (state_q != S_FLAT) begin
                    state_d = S_FLAT;
                    code_d  = floor_code;
                end
            end else begin
                unique case (state_q)
                    S_CLIMB: begin
                        code_d = up_code;
                        if (up_hit)
                            state_d = (shape == SH_SAW_UP) ? S_SNAP_LO : S_DESCEND;
                    end
                    S_DESCEND: begin
                        code_d = dn_code;
                        if (dn_hit)
                            state_d = (shape == SH_SAW_DOWN) ? S_SNAP_HI : S_CLIMB;
                    end
                    S_SNAP_LO: begin
                        code_d  = floor_code;
                        state_d = S_CLIMB;
                    end
                    S_SNAP_HI: begin
                        code_d  = ceil_code;
                        state_d = S_DESCEND;
                    end
                    S_SQ_LOW: begin
                        code_d  = ceil_code;
                        state_d = S_SQ_HIGH;
                    end
                    S_SQ_HIGH: begin
                        code_d  = floor_code;
                        state_d = S_SQ_LOW;
                    end
                    S_FLAT: begin
                        code_d  = entry_code;
                        state_d = entry_state;
                    end
                    S_IDLE: begin
                        state_d = S_IDLE;
                    end
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            stb_q  <= 1'b0;
        end else begin
            code_q <= code_d;
            stb_q  <= (code_d != code_q);
        end
    end

    // R11: strobe only when the code moved
    a_r11_stb_means_change: assert property (@(posedge clk) disable iff (!rst_n)
        stb_q |-> (code_q != $past(code_q)));

    // R11: every code change is strobed
    a_r11_change_means_stb: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q != $past(code_q)) |-> stb_q);

    // R1: a low run control freezes the code
    a_r1_frozen_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run_en) |-> !stb_q);

    // R10: the flat state never moves the code
    a_r10_flat_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FLAT && $past(state_q) == S_FLAT) |-> $stable(code_q));

    // R8: ramp states stay inside unchanged bounds
    a_r8_in_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_CLIMB || state_q == S_DESCEND) && $stable(ceil_code)
         && $stable(floor_code) && $past(state_q) != S_IDLE && $past(bounds_ok))
        |-> (code_q >= floor_code && code_q <= ceil_code));

endmodule

// File: rtl/wavegen_seq.sv
module wavegen_seq #(
    parameter int CODE_W    = 10,
    parameter int STEP_W    = 2,
    parameter int PACE_W    = 4,
    parameter int TIMER_W   = 12,
    parameter int LIN_STEPS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic [1:0]        shape_sel,
    input  logic [STEP_W-1:0] step_sel,
    input  logic [PACE_W-1:0] pace_sel,
    input  logic [CODE_W-1:0] code_hi,
    input  logic [CODE_W-1:0] code_lo,
    output logic [CODE_W-1:0] code_out,
    output logic              update_stb
);
    logic              running;
    logic              tick;
    logic [CODE_W-1:0] up_code;
    logic [CODE_W-1:0] dn_code;
    logic              up_hit;
    logic              dn_hit;
    logic              bounds_ok;

    wg_pace_timer #(
        .SEL_W     (PACE_W),
        .CNT_W     (TIMER_W),
        .LIN_STEPS (LIN_STEPS)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .running  (running),
        .pace_sel (pace_sel),
        .tick     (tick)
    );

    wg_step_unit #(
        .CODE_W (CODE_W),
        .STEP_W (STEP_W)
    ) u_step (
        .code_now   (code_out),
        .step_sel   (step_sel),
        .ceil_code  (code_hi),
        .floor_code (code_lo),
        .up_code    (up_code),
        .up_hit     (up_hit),
        .dn_code    (dn_code),
        .dn_hit     (dn_hit),
        .bounds_ok  (bounds_ok)
    );

    wg_seq_fsm #(
        .CODE_W (CODE_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .shape_sel  (shape_sel),
        .tick       (tick),
        .ceil_code  (code_hi),
        .floor_code (code_lo),
        .up_code    (up_code),
        .up_hit     (up_hit),
        .dn_code    (dn_code),
        .dn_hit     (dn_hit),
        .bounds_ok  (bounds_ok),
        .running    (running),
        .code_q     (code_out),
        .stb_q      (update_stb)
    );

    // R12: reset values
    always_comb begin
        if (!rst_n) begin
            a_r12_reset_quiet: assert (update_stb == 1'b0);
        end
    end

endmodule

// File: tb/wavegen_seq_tb_top.sv
`timescale 1ns/1ps
module wavegen_seq_tb_top;

    typedef struct packed {
        logic [1:0]       shape;
        logic [1:0]       stp;
        logic [3:0]       pace;
        logic [9:0]       hi;
        logic [9:0]       lo;
        logic [0:7][9:0]  codes;
    } vec_t;

    // shape, step_sel, pace_sel, hi, lo, first eight codes from the start edge
    localparam vec_t VECS [0:5] = '{
        '{2'd0, 2'd2, 4'd0, 10'd20,   10'd10,
          '{10'd10, 10'd13, 10'd16, 10'd19, 10'd20, 10'd17, 10'd14, 10'd11}},
        '{2'd1, 2'd3, 4'd2, 10'd108,  10'd100,
          '{10'd100, 10'd104, 10'd108, 10'd100, 10'd104, 10'd108, 10'd100, 10'd104}},
        '{2'd2, 2'd1, 4'd1, 10'd55,   10'd50,
          '{10'd55, 10'd53, 10'd51, 10'd50, 10'd55, 10'd53, 10'd51, 10'd50}},
        '{2'd3, 2'd0, 4'd3, 10'd1008, 10'd5,
          '{10'd5, 10'd1008, 10'd5, 10'd1008, 10'd5, 10'd1008, 10'd5, 10'd1008}},
        '{2'd0, 2'd0, 4'd0, 10'd3,    10'd0,
          '{10'd0, 10'd1, 10'd2, 10'd3, 10'd2, 10'd1, 10'd0, 10'd1}},
        '{2'd0, 2'd3, 4'd8, 10'd1023, 10'd1020,
          '{10'd1020, 10'd1023, 10'd1020, 10'd1023, 10'd1020, 10'd1023, 10'd1020, 10'd1023}}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic [1:0] shape_sel = 2'd0;
    logic [1:0] step_sel = 2'd0;
    logic [3:0] pace_sel = 4'd0;
    logic [9:0] code_hi = 10'd0;
    logic [9:0] code_lo = 10'd0;
    logic [9:0] code_out;
    logic       update_stb;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    wavegen_seq dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .shape_sel  (shape_sel),
        .step_sel   (step_sel),
        .pace_sel   (pace_sel),
        .code_hi    (code_hi),
        .code_lo    (code_lo),
        .code_out   (code_out),
        .update_stb (update_stb)
    );

    function automatic int pace_cycles(input int s);
        return (s < 8) ? s + 1 : (1 << (s - 4));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_stb(output int cycles);
        cycles = 0;
        do begin
            @(negedge clk);
            cycles++;
        end while (!update_stb && cycles < 5000);
    endtask

    task automatic begin_run(input int shp, input int stp, input int pace,
                             input int hi, input int lo);
        @(negedge clk);
        run_en    = 1'b0;
        shape_sel = 2'(shp);
        step_sel  = 2'(stp);
        pace_sel  = 4'(pace);
        code_hi   = 10'(hi);
        code_lo   = 10'(lo);
        repeat (2) @(negedge clk);
        run_en = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int cyc;
        logic [9:0] held;

        // R12: reset state
        repeat (3) @(negedge clk);
        chk(code_out == 10'd0, "R12 code", int'(code_out), 0);
        chk(update_stb == 1'b0, "R12 stb", int'(update_stb), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(code_out == 10'd0 && !update_stb, "R1 idle after reset", int'(code_out), 0);

        // table walk: R2 R3 R4 R5 R6 R7 R8 R9 R11
        for (int v = 0; v < 6; v++) begin
            begin_run(int'(VECS[v].shape), int'(VECS[v].stp), int'(VECS[v].pace),
                      int'(VECS[v].hi), int'(VECS[v].lo));
            chk(code_out == VECS[v].codes[0], "R2 start code",
                int'(code_out), int'(VECS[v].codes[0]));
            for (int k = 1; k < 8; k++) begin
                wait_stb(cyc);
                chk(cyc == pace_cycles(int'(VECS[v].pace)), "R9 R11 move spacing",
                    cyc, pace_cycles(int'(VECS[v].pace)));
                chk(code_out == VECS[v].codes[k], "R3 R4 R5 R6 R7 R8 code",
                    int'(code_out), int'(VECS[v].codes[k]));
            end
        end

        // R1: stopping mid-wave freezes the code
        begin_run(0, 0, 1, 40, 0);
        wait_stb(cyc);
        wait_stb(cyc);
        run_en = 1'b0;
        held = code_out;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(!update_stb, "R1 no strobe when stopped", int'(update_stb), 0);
        end
        chk(code_out == held, "R1 code frozen", int'(code_out), int'(held));

        // R10: inverted bounds
        begin_run(0, 1, 0, 5, 9);
        chk(code_out == 10'd9, "R10 inverted holds floor", int'(code_out), 9);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            chk(!update_stb && code_out == 10'd9, "R10 inverted no move", int'(code_out), 9);
        end

        // R10: equal bounds, falling sawtooth still holds the floor
        begin_run(2, 0, 0, 300, 300);
        chk(code_out == 10'd300, "R10 equal holds floor", int'(code_out), 300);
        repeat (30) @(negedge clk);
        chk(code_out == 10'd300, "R10 equal no move", int'(code_out), 300);

        // R9: slowest pace on a square wave
        begin_run(3, 0, 15, 1, 0);
        wait_stb(cyc);
        chk(cyc == 2048, "R9 slowest pace", cyc, 2048);
        chk(code_out == 10'd1, "R6 square high", int'(code_out), 1);
        @(negedge clk);
        chk(!update_stb, "R11 one cycle pulse", int'(update_stb), 0);

        // R12: reset mid-run clears the outputs
        rst_n = 1'b0;
        @(negedge clk);
        chk(code_out == 10'd0 && !update_stb, "R12 reset mid-run", int'(code_out), 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule